// File: doc/BRIEF.md
# Edge-Ordered Set/Clear Bit

This block keeps a single stored bit that follows whichever of two level inputs, the set level or the clear level, went from low to high most recently. The levels themselves do not decide the bit. A rising set level makes the bit 1 and a rising clear level makes it 0. Falling levels and returns to both-low leave the bit unchanged. So when both levels are high, the bit keeps the value chosen by the later of the two rising edges.

The block is a clocked machine. On every clock edge it samples the two levels and tracks a total state: the last accepted pair of levels plus the stored bit. That gives eight total states, with four input pairs for each value of the bit. The block expects at most one of the two levels to change between consecutive samples. If both change in the same sample, the block holds the bit, takes the new pair as its reference and raises a one-cycle protocol error. Input synchronisation is left to the surrounding logic.

Top module: `esr_edge_flop`

## Requirements
- R1: While `rst_n` is low at a clock edge, the next outputs are `q`=0 and `proto_err`=0, and the reference input pair becomes set=0, clear=0.
- R2: The first sample after reset is taken as the new reference. It is not treated as an edge, so `q` stays 0 and `proto_err` stays 0 even if the set level is already high.
- R3: When the set level rises and the clear level is unchanged, `q` becomes 1 (pair 00 to 10).
- R4: When the clear level rises and the set level is unchanged, `q` becomes 0 (pair 00 to 01).
- R5: The newest rising edge wins. Going from pair 01 to pair 11 gives `q`=1, and going from pair 10 to pair 11 gives `q`=0.
- R6: A falling edge on either level never changes `q`. For example, 11 with `q`=1 to 01 keeps 1, and 11 with `q`=0 to 10 keeps 0.
- R7: A return to pair 00 keeps the current `q`.
- R8: If both levels change in one sample, `q` is held and `proto_err` is 1 for exactly the following cycle. The new pair becomes the reference, so a later single change is handled as a normal edge.
- R9: `q` is registered. It changes at the first clock edge that samples the input change, and not earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all sampling happens on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| set_lvl | input | 1 | Set level; its rising edge makes the bit 1 |
| clr_lvl | input | 1 | Clear level; its rising edge makes the bit 0 |
| q | output | 1 | Stored bit, registered |
| proto_err | output | 1 | One-cycle flag raised when both levels changed in one sample |

## Verification
The block has no tuning parameters, so the bench builds it as it is. The directed sequences reach all eight total states. They cover both orders in which the levels can reach the both-high pair, every falling transition out of both-high, and returns to both-low with each value of the bit. A separate task checks the first sample after reset with the set level already high. Two kinds of double change are covered: both-low to both-high, and a swap between the two single-high pairs. Each is followed by a single change, which confirms that the new reference was taken.

// File: rtl/esr_pkg.sv
// Package: shared types for the edge-ordered set/clear bit.
// Assumes: a two-bit input pair (set, clear) sampled once per clock.
package esr_pkg;

    localparam int PAIR_W = 2;

    // Total state: remembered bit plus the last accepted input pair.
    typedef struct packed {
        logic q;
        logic s;
        logic c;
    } total_t;

    // Edge events seen between the reference pair and the current sample.
    typedef struct packed {
        logic s_rise;
        logic c_rise;
        logic both;
    } edge_ev_t;

    localparam total_t TOTAL_RESET = '{q: 1'b0, s: 1'b0, c: 1'b0};

endpackage

// File: rtl/esr_edge_detect.sv
// Module: compares the sampled input pair with the reference pair and
// reports rising edges and a simultaneous change of both levels.
// Assumes: reference pair comes from the owner's state register.
module esr_edge_detect
    import esr_pkg::*;
(
    input  logic     prev_s,
    input  logic     prev_c,
    input  logic     cur_s,
    input  logic     cur_c,
    output edge_ev_t ev
);

    logic [PAIR_W-1:0] diff;

    // Purpose: mark which levels differ from the reference and which rose.
    always_comb begin
        diff      = {cur_s ^ prev_s, cur_c ^ prev_c};
        ev.s_rise = cur_s & ~prev_s;
        ev.c_rise = cur_c & ~prev_c;
        ev.both   = &diff;
    end

endmodule

// File: rtl/esr_next.sv
// Module: next total state and error decision for the edge-ordered bit.
// Assumes: primed is low only for the first sample after reset.
module esr_next
    import esr_pkg::*;
(
    input  total_t   cur,
    input  edge_ev_t ev,
    input  logic     primed,
    input  logic     set_lvl,
    input  logic     clr_lvl,
    output total_t   nxt,
    output logic     err
);

    // Purpose: pick next bit from the newest rising edge; always track levels.
    always_comb begin
        nxt   = cur;
        err   = 1'b0;
        nxt.s = set_lvl;
        nxt.c = clr_lvl;
        if (primed) begin
            if (ev.both) begin
                err = 1'b1;
            end else if (ev.s_rise) begin
                nxt.q = 1'b1;
            end else if (ev.c_rise) begin
                nxt.q = 1'b0;
            end
        end
    end

endmodule

// File: rtl/esr_edge_flop.sv
// Module: top of the edge-ordered set/clear bit. Holds the total state,
// the post-reset priming flag and the registered error flag.
// Assumes: levels are already synchronous to clk; at most one changes per sample.
module esr_edge_flop
    import esr_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic set_lvl,
    input  logic clr_lvl,
    output logic q,
    output logic proto_err
);

    total_t   track;
    total_t   nxt_track;
    edge_ev_t ev;
    logic     primed;
    logic     nxt_err;

    esr_edge_detect u_det (
        .prev_s (track.s),
        .prev_c (track.c),
        .cur_s  (set_lvl),
        .cur_c  (clr_lvl),
        .ev     (ev)
    );

    esr_next u_nxt (
        .cur     (track),
        .ev      (ev),
        .primed  (primed),
        .set_lvl (set_lvl),
        .clr_lvl (clr_lvl),
        .nxt     (nxt_track),
        .err     (nxt_err)
    );

    // Purpose: total-state, priming and error registers with synchronous reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            track     <= TOTAL_RESET;
            primed    <= 1'b0;
            proto_err <= 1'b0;
        end else begin
            track     <= nxt_track;
            primed    <= 1'b1;
            proto_err <= nxt_err;
        end
    end

    assign q = track.q;

    // R1: reset forces a cleared bit and no error
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (!q && !proto_err));

    // R2: first sample after reset is never an edge
    p_first_ref_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !primed |=> (!q && !proto_err));

    // R3: lone set rise gives q=1
    p_set_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && set_lvl && !track.s && (clr_lvl == track.c)) |=> q);

    // R4: lone clear rise gives q=0
    p_clr_rise_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && clr_lvl && !track.c && (set_lvl == track.s)) |=> !q);

    // R6: a lone falling level keeps q
    p_fall_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && ((!set_lvl && track.s && (clr_lvl == track.c)) ||
                    (!clr_lvl && track.c && (set_lvl == track.s)))) |=> $stable(q));

    // R8: double change holds q and raises the flag
    p_double_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (primed && (set_lvl != track.s) && (clr_lvl != track.c)) |=> (proto_err && $stable(q)));

endmodule

// File: tb/sim_esr_edge_flop.sv
module sim_esr_edge_flop;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic set_lvl = 1'b0;
    logic clr_lvl = 1'b0;
    logic q;
    logic proto_err;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    esr_edge_flop u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .set_lvl   (set_lvl),
        .clr_lvl   (clr_lvl),
        .q         (q),
        .proto_err (proto_err)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    // Drive a pair at a falling edge, let one rising edge sample it, return at next falling edge.
    task automatic apply(input logic s, input logic c);
        @(negedge clk);
        set_lvl = s;
        clr_lvl = c;
        @(negedge clk);
    endtask

    task automatic do_reset(input logic s, input logic c);
        @(negedge clk);
        rst_n = 1'b0;
        set_lvl = s;
        clr_lvl = c;
        repeat (2) @(negedge clk);
        chk("R1 q after reset", q, 1'b0);
        chk("R1 proto_err after reset", proto_err, 1'b0);
        rst_n = 1'b1;
    endtask

    task automatic t_first_sample;
        do_reset(1'b1, 1'b0);
        @(negedge clk);
        chk("R2 q on first sample with set high", q, 1'b0);
        chk("R2 no error on first sample", proto_err, 1'b0);
        apply(1'b0, 1'b0);
        chk("R6 set fall after priming keeps q", q, 1'b0);
        apply(1'b1, 1'b0);
        chk("R3 set rise from 00", q, 1'b1);
    endtask

    task automatic t_single_edges;
        do_reset(1'b0, 1'b0);
        apply(1'b0, 1'b0);
        apply(1'b1, 1'b0);
        chk("R3 set rise 00->10", q, 1'b1);
        apply(1'b0, 1'b0);
        chk("R7 return to 00 keeps 1", q, 1'b1);
        apply(1'b0, 1'b1);
        chk("R4 clear rise 00->01", q, 1'b0);
        apply(1'b0, 1'b0);
        chk("R7 return to 00 keeps 0", q, 1'b0);
    endtask

    task automatic t_newest_wins;
        do_reset(1'b0, 1'b0);
        apply(1'b0, 1'b0);
        apply(1'b0, 1'b1);
        apply(1'b1, 1'b1);
        chk("R5 01->11 sets", q, 1'b1);
        apply(1'b0, 1'b1);
        chk("R6 11->01 keeps 1", q, 1'b1);
        apply(1'b1, 1'b1);
        apply(1'b1, 1'b0);
        chk("R6 11->10 keeps 1", q, 1'b1);
        apply(1'b1, 1'b1);
        chk("R5 10->11 clears", q, 1'b0);
        apply(1'b1, 1'b0);
        chk("R6 11->10 keeps 0", q, 1'b0);
        apply(1'b1, 1'b1);
        apply(1'b0, 1'b1);
        chk("R6 11->01 keeps 0", q, 1'b0);
        chk("R8 no error on single changes", proto_err, 1'b0);
    endtask

    task automatic t_registered;
        do_reset(1'b0, 1'b0);
        apply(1'b0, 1'b0);
        apply(1'b1, 1'b0);
        @(negedge clk);
        clr_lvl = 1'b1;
        #2;
        chk("R9 q unchanged before sampling edge", q, 1'b1);
        @(negedge clk);
        chk("R9 q follows at sampling edge", q, 1'b0);
    endtask

    task automatic t_double_change;
        do_reset(1'b0, 1'b0);
        apply(1'b0, 1'b0);
        apply(1'b1, 1'b0);
        apply(1'b0, 1'b0);
        apply(1'b1, 1'b1);
        chk("R8 00->11 holds q", q, 1'b1);
        chk("R8 00->11 raises flag", proto_err, 1'b1);
        apply(1'b1, 1'b1);
        chk("R8 flag lasts one cycle", proto_err, 1'b0);
        apply(1'b1, 1'b0);
        chk("R8 new reference, clear fall keeps q", q, 1'b1);
        chk("R8 no flag after reference taken", proto_err, 1'b0);
        apply(1'b0, 1'b1);
        chk("R8 10->01 swap holds q", q, 1'b1);
        chk("R8 10->01 swap raises flag", proto_err, 1'b1);
        apply(1'b1, 1'b1);
        chk("R5 set rise after swap reference", q, 1'b1);
        apply(1'b0, 1'b1);
        apply(1'b0, 1'b0);
        apply(1'b1, 1'b0);
        apply(1'b1, 1'b1);
        chk("R5 clear rise after swap recovery", q, 1'b0);
    endtask

    initial begin
        t_first_sample();
        t_single_edges();
        t_newest_wins();
        t_registered();
        t_double_change();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

endmodule